// File: doc/BRIEF.md
# Q-Channel Device Power Handshake Responder

This block sits on the device side of a quiescence handshake with a power controller. The controller lowers an active-low request when it wants the device to go quiet. The block answers in one of two ways. It can lower an active-low accept, which grants the request, or it can raise an active-high deny, which refuses it. Two further outputs go upward: an activity hint that tells the controller whether the device has work, and a wake-up indication that signals a pending return to operation.

Three local status flags decide whether a request is granted. The first reports a non-interruptible transfer in flight. The second is internal: a stabilisation window that runs for a set number of cycles after each exit from low power. The third is a lock that holds the device in a high-performance mode. Any one of them causes a refusal. The request input crosses clock domains, so it passes through a flop synchroniser before the phase machine acts on it. The phase machine moves through running, requested, stopped, exiting and refused phases. All outputs are registered.

Top module: `qchan_responder`

## Requirements
- R1: After synchronous reset the block is in the running phase with accept_n=1, deny=0, active=1 and wakeup=0.
- R2: req_n_async passes through a two-flop synchroniser. With no refusal cause present, accept_n falls on the fourth rising clock edge after req_n_async falls, and is still 1 after the third edge.
- R3: Whenever the block is in the running phase, active is 1 and deny is 0.
- R4: A request whose decision is taken while crit_busy=1 is refused: deny rises and accept_n stays 1.
- R5: A request whose decision is taken while perf_lock=1 is refused: deny rises and accept_n stays 1.
- R6: For STAB_CYC cycles after the block leaves the stopped phase, a new request is refused.
- R7: Once raised, deny stays 1 until the synchronised request returns high. It then falls on the third edge after req_n_async rises and the block returns to running.
- R8: In the stopped phase active=0 and wakeup=0. Raising wake_need raises wakeup on the next edge and active one edge after that, while accept_n stays 0.
- R9: A rising request in the stopped phase drives accept_n to 1 and wakeup to 1 on the third edge. If active is 0, it rises one edge later. wakeup falls one edge after active is seen high, and the block re-enters running.
- R10: accept_n=0 and deny=1 never occur together, and the two never change on the same edge.
- R11: accept_n and deny change only after a change of the synchronised request: they fall only after a low request and rise only after a high request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n_async | input | 1 | Active-low quiescence request from the power controller, asynchronous |
| crit_busy | input | 1 | Non-interruptible transfer in progress |
| perf_lock | input | 1 | High-performance mode lock that forbids low power |
| wake_need | input | 1 | Internal need to wake while stopped |
| accept_n | output | 1 | Active-low grant of the quiescence request |
| deny | output | 1 | Active-high refusal of the quiescence request |
| active | output | 1 | Activity hint to the controller |
| wakeup | output | 1 | Wake-up indication to the controller |

## Verification
The embedded properties assume that the controller follows the handshake. It keeps the request low until an answer appears, and it raises the request only after an accept or a deny. They also assume that wake_need stays high in the stopped phase until the request rises. The bench holds the request level for whole answer intervals. It changes crit_busy, perf_lock and wake_need only on falling edges, and only before or well after a decision, never near one. It waits out the stabilisation window before each scenario that expects a grant.

// File: rtl/qchan_pkg.sv
package qchan_pkg;
  typedef enum logic [2:0] {
    PH_RUN  = 3'd0,
    PH_REQ  = 3'd1,
    PH_STOP = 3'd2,
    PH_EXIT = 3'd3,
    PH_DENY = 3'd4
  } qphase_e;
endpackage

// File: rtl/qchan_sync.sv
module qchan_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/qchan_stab_timer.sv
module qchan_stab_timer #(
  parameter int STAB_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(STAB_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STAB_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (start)       cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R6
  stab_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD);

  // R6
  stab_load_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: rtl/qchan_phase_fsm.sv
module qchan_phase_fsm
  import qchan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic crit_busy,
  input  logic perf_lock,
  input  logic stab_busy,
  input  logic wake_need,
  output logic start_stab,
  output logic accept_n,
  output logic deny,
  output logic active,
  output logic wakeup
);
  qphase_e ph, ph_n;
  logic refuse;

  assign refuse     = crit_busy | perf_lock | stab_busy;
  assign start_stab = (ph == PH_STOP) && req_s;

  always_comb begin
    ph_n = ph;
    unique case (ph)
      PH_RUN:  if (!req_s) ph_n = PH_REQ;
      PH_REQ:  ph_n = refuse ? PH_DENY : PH_STOP;
      PH_STOP: if (req_s) ph_n = PH_EXIT;
      PH_EXIT: if (active) ph_n = PH_RUN;
      PH_DENY: if (req_s) ph_n = PH_RUN;
      default: ph_n = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_RUN;
      accept_n <= 1'b1;
      deny     <= 1'b0;
      active   <= 1'b1;
      wakeup   <= 1'b0;
    end else begin
      ph       <= ph_n;
      accept_n <= (ph_n != PH_STOP);
      deny     <= (ph_n == PH_DENY);
      wakeup   <= (ph_n == PH_EXIT) || ((ph_n == PH_STOP) && wake_need);
      active   <= (ph_n == PH_RUN) || (ph_n == PH_REQ) || (ph_n == PH_DENY) ||
                  (((ph_n == PH_EXIT) || (ph_n == PH_STOP)) && wakeup);
    end
  end

  // R3
  run_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_RUN) |-> (active && !deny));

  // R4
  crit_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_REQ) && crit_busy) |=> (deny && accept_n));

  // R5
  lock_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_REQ) && perf_lock) |=> (deny && accept_n));

  // R6
  stab_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    ((ph == PH_REQ) && stab_busy) |=> deny);

  // R7
  deny_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (deny && !req_s) |=> deny);

  // R9
  wake_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wakeup) |-> !active);

  // R9
  wake_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wakeup) |-> active);

  // R10
  no_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(!accept_n && deny));

  // R10
  no_joint_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(accept_n) |-> $stable(deny));

  // R11
  accept_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(accept_n) |-> !$past(req_s));

  // R11
  accept_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(accept_n) |-> $past(req_s));

  // R11
  deny_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(deny) |-> !$past(req_s));

  // R11
  deny_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(deny) |-> $past(req_s));
endmodule

// File: rtl/qchan_responder.sv
module qchan_responder #(
  parameter int SYNC_STAGES = 2,
  parameter int STAB_CYC    = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic req_n_async,
  input  logic crit_busy,
  input  logic perf_lock,
  input  logic wake_need,
  output logic accept_n,
  output logic deny,
  output logic active,
  output logic wakeup
);
  logic req_s;
  logic stab_busy;
  logic start_stab;

  qchan_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (req_n_async),
    .dout (req_s)
  );

  qchan_stab_timer #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk   (clk),
    .rst   (rst),
    .start (start_stab),
    .busy  (stab_busy)
  );

  qchan_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_s      (req_s),
    .crit_busy  (crit_busy),
    .perf_lock  (perf_lock),
    .stab_busy  (stab_busy),
    .wake_need  (wake_need),
    .start_stab (start_stab),
    .accept_n   (accept_n),
    .deny       (deny),
    .active     (active),
    .wakeup     (wakeup)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (accept_n && !deny && active && !wakeup));
endmodule

// File: tb/sim_qchan_responder.sv
module sim_qchan_responder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_n_async = 1'b1;
  logic crit_busy = 1'b0;
  logic perf_lock = 1'b0;
  logic wake_need = 1'b0;
  logic accept_n, deny, active, wakeup;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  qchan_responder #(.SYNC_STAGES(2), .STAB_CYC(16)) u0 (
    .clk(clk), .rst(rst), .req_n_async(req_n_async),
    .crit_busy(crit_busy), .perf_lock(perf_lock), .wake_need(wake_need),
    .accept_n(accept_n), .deny(deny), .active(active), .wakeup(wakeup)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    edges(3);
    @(negedge clk) rst = 1'b0;
    edges(1);
    chk("R1 accept_n", accept_n, 1'b1);
    chk("R1 deny", deny, 1'b0);
    chk("R1 active", active, 1'b1);
    chk("R1 wakeup", wakeup, 1'b0);
    edges(20);
  endtask

  task automatic t_accept;
    @(negedge clk) req_n_async = 1'b0;
    edges(3);
    chk("R2 accept_n held by sync", accept_n, 1'b1);
    edges(1);
    chk("R2 accept_n granted", accept_n, 1'b0);
    chk("R10 deny low on grant", deny, 1'b0);
    chk("R8 active low stopped", active, 1'b0);
    chk("R8 wakeup low stopped", wakeup, 1'b0);
  endtask

  task automatic t_exit;
    @(negedge clk) req_n_async = 1'b1;
    edges(2);
    chk("R11 accept_n waits on sync", accept_n, 1'b0);
    edges(1);
    chk("R9 accept_n high", accept_n, 1'b1);
    chk("R9 wakeup high", wakeup, 1'b1);
    chk("R9 active still low", active, 1'b0);
    edges(1);
    chk("R9 active rises", active, 1'b1);
    chk("R9 wakeup overlap", wakeup, 1'b1);
    edges(1);
    chk("R9 wakeup drops", wakeup, 1'b0);
    chk("R3 active in run", active, 1'b1);
    chk("R3 deny low in run", deny, 1'b0);
  endtask

  task automatic t_stab_refuse;
    @(negedge clk) req_n_async = 1'b0;
    edges(4);
    chk("R6 deny in window", deny, 1'b1);
    chk("R6 accept_n high in window", accept_n, 1'b1);
    edges(6);
    chk("R7 deny held", deny, 1'b1);
    @(negedge clk) req_n_async = 1'b1;
    edges(2);
    chk("R7 deny until sync high", deny, 1'b1);
    edges(1);
    chk("R7 deny drops", deny, 1'b0);
    chk("R3 active after deny", active, 1'b1);
    chk("R10 accept_n high after deny", accept_n, 1'b1);
    edges(30);
  endtask

  task automatic t_flag_refuse(input string tag, input bit use_lock);
    @(negedge clk) begin
      crit_busy = !use_lock;
      perf_lock = use_lock;
      req_n_async = 1'b0;
    end
    edges(4);
    chk({tag, " deny"}, deny, 1'b1);
    chk({tag, " accept_n"}, accept_n, 1'b1);
    @(negedge clk) req_n_async = 1'b1;
    edges(3);
    chk({tag, " deny released"}, deny, 1'b0);
    @(negedge clk) begin
      crit_busy = 1'b0;
      perf_lock = 1'b0;
    end
    edges(5);
  endtask

  task automatic t_wake;
    t_accept();
    edges(5);
    chk("R8 still stopped", accept_n, 1'b0);
    @(negedge clk) wake_need = 1'b1;
    edges(1);
    chk("R8 wakeup rises", wakeup, 1'b1);
    chk("R8 active not yet", active, 1'b0);
    edges(1);
    chk("R8 active follows", active, 1'b1);
    chk("R8 accept_n stays low", accept_n, 1'b0);
    @(negedge clk) req_n_async = 1'b1;
    edges(3);
    chk("R9 accept_n high on wake exit", accept_n, 1'b1);
    chk("R9 wakeup high on wake exit", wakeup, 1'b1);
    edges(1);
    chk("R9 wakeup drops on wake exit", wakeup, 1'b0);
    chk("R3 active back in run", active, 1'b1);
    @(negedge clk) wake_need = 1'b0;
    edges(30);
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_accept();
    t_exit();
    t_stab_refuse();
    t_flag_refuse("R4 crit", 1'b0);
    t_flag_refuse("R5 lock", 1'b1);
    t_wake();
    t_accept();
    t_exit();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule